// File: doc/BRIEF.md
# VPW Bus Frame Receiver

This block receives frames from a single-wire bus that uses variable pulse width coding. The bus input can come straight from a comparator. It is first synchronised and glitch-filtered. The block then measures how long each high and low level lasts, counting in ticks from a local prescaler. Each level is sorted by its duration into a symbol class: start of frame, data bit, end of data, normalization bit, end of frame or break. A bit's value depends on both its width and its level. The idle bus rests low.

Data bits are packed most significant bit first into bytes and delivered on a valid/data strobe. A serial CRC runs over the data field, and over the in-frame response when the normalization bit says that field carries its own check byte. Frame milestones and their error flags appear on a separate event strobe. A mode input makes the prescaler tick four times faster, so the same duration windows fit a bus running at four times the rate. Bus drive, analog thresholds and edge shaping are handled elsewhere.

Top module: `vpw_frame_rx`

## Requirements
- R1: After a two-flop synchroniser, a level on `bus_in` is taken only once it has held for FILT_CLKS consecutive clocks. A shorter glitch, whether on the idle bus or inside a symbol, changes no output.
- R2: While no frame is open, a high level of 163 to 238 ticks opens a frame and raises `ev_valid` with `ev_kind` = 0 (start), `ev_flags` = 0. The start symbol is not part of the CRC.
- R3: Inside the data field or the response field, a level of 34 to 95 ticks is short and one of 96 to 162 ticks is long. A low short level or a high long level is a 1. A low long level or a high short level is a 0. Every eight bits give one byte, most significant bit first, on `rx_data` with a one-cycle `rx_valid`.
- R4: When a low level in the data field reaches 163 ticks, the block raises event kind 1 (end of data). Flag bit 0 is set when the CRC register does not equal 0xC4. That register is preset to 0xFF, uses polynomial x^8+x^4+x^3+x^2+1, and is fed each bit most significant first, including the inverted check byte. Flag bit 2 is set when the field is empty or ends in a partial byte.
- R5: After end of data, a high short or long level is the normalization bit, reported as kind 2. Flag bit 0 is 1 for the long form, which means the response carries a check byte. The bytes that follow are delivered with `rx_resp` = 1.
- R6: When a low level inside an open frame reaches 239 ticks, the block raises kind 3 (end of frame) and closes the frame. Its flags are bit 2 framing error, bit 1 length error, and bit 0 CRC error of the data field or of a response that carries a check byte.
- R7: At most MAX_BYTES (12) bytes are delivered between start and end of frame, counting data and response together. Later bytes are dropped, and flag bit 1 is set in the end-of-data and end-of-frame events that follow.
- R8: A high level reaching 239 ticks is a break. It raises kind 4 with flags 0 at any time and aborts the frame. No byte is delivered again until the next start symbol.
- R9: Inside a frame, a level under 34 ticks or a misplaced symbol stops byte delivery for the rest of the frame, and the end-of-frame event carries flag bit 2.
- R10: With `fast_mode` = 1 one tick is CLKS_PER_US/4 clocks instead of CLKS_PER_US, so every duration window is four times shorter.
- R11: `rx_valid` and `ev_valid` are never high in the same cycle.
- R12: While `rst` is high and in the first cycle after it, `rx_valid` and `ev_valid` are 0 and no frame is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fast_mode | input | 1 | 1 selects the four-times tick rate |
| bus_in | input | 1 | Raw bus level, high = active |
| rx_valid | output | 1 | One-cycle strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_resp | output | 1 | Byte belongs to the in-frame response |
| ev_valid | output | 1 | One-cycle strobe for a frame event |
| ev_kind | output | 3 | 0 start, 1 end of data, 2 normalization, 3 end of frame, 4 break |
| ev_flags | output | 3 | Flags for the event (see R4 to R6) |

## Verification
The bench builds the block with CLKS_PER_US = 4 and FILT_CLKS = 3. With these values a two-clock glitch falls just under the filter length. A three-clock level would pass, so R1 is tested at its boundary. They also make the four-times mode tick once per clock. That keeps the over-length frame, the break and the short-pulse cases cheap, while several normal-speed frames still run. Random payloads, normalization forms and corrupted check bytes are mixed with the directed cases.

// File: rtl/vpw_rx_pkg.sv
package vpw_rx_pkg;

    // Duration windows in ticks (one tick = 1 us at normal speed)
    localparam int unsigned T_MIN       = 34;
    localparam int unsigned T_SHORT_END = 96;
    localparam int unsigned T_LONG_END  = 163;
    localparam int unsigned T_OVER      = 239;

    localparam logic [7:0] CRC_INIT = 8'hFF;
    localparam logic [7:0] CRC_POLY = 8'h1D;
    localparam logic [7:0] CRC_GOOD = 8'hC4;

    typedef enum logic [2:0] {
        SYM_NONE, SYM_BIT, SYM_SOF, SYM_EOD, SYM_EOF, SYM_BRK, SYM_BAD
    } sym_e;

    typedef enum logic [2:0] {
        EV_SOF = 3'd0, EV_EOD = 3'd1, EV_NB = 3'd2, EV_EOF = 3'd3, EV_BRK = 3'd4
    } ev_e;

    typedef enum logic [2:0] {
        FS_IDLE, FS_DATA, FS_GAP, FS_RESP, FS_TAIL
    } fstate_e;

    function automatic logic [7:0] crc_bit(input logic [7:0] c, input logic b);
        logic fb;
        fb = c[7] ^ b;
        return {c[6:0], 1'b0} ^ (fb ? CRC_POLY : 8'h00);
    endfunction

endpackage

// File: rtl/vpw_rx_tick.sv
module vpw_rx_tick #(
    parameter int unsigned CLKS_PER_US = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic fast_mode,
    output logic tick
);
    localparam int unsigned QUARTER = CLKS_PER_US / 4;
    localparam int unsigned DIV_W   = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [DIV_W-1:0] LIM_N = DIV_W'(CLKS_PER_US - 1);
    localparam logic [DIV_W-1:0] LIM_F = DIV_W'(QUARTER - 1);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } tick_t;

    tick_t q, d;
    logic [DIV_W-1:0] limit;

    always_comb begin
        d     = q;
        limit = fast_mode ? LIM_F : LIM_N;
        if (q.cnt >= limit) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt  = q.cnt + 1'b1;
            d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign tick = q.tick;
endmodule

// File: rtl/vpw_rx_filter.sv
module vpw_rx_filter #(
    parameter int unsigned FILT_CLKS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bus_raw,
    output logic level
);
    localparam int unsigned FW = $clog2(FILT_CLKS + 1);
    localparam logic [FW-1:0] HOLD_LAST = FW'(FILT_CLKS - 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          lvl;
        logic [FW-1:0] cnt;
    } filt_t;

    filt_t q, d;

    always_comb begin
        d    = q;
        d.s1 = bus_raw;
        d.s2 = q.s1;
        if (q.s2 != q.lvl) begin
            if (q.cnt == HOLD_LAST) begin
                d.lvl = q.s2;
                d.cnt = '0;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end else begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign level = q.lvl;
endmodule

// File: rtl/vpw_rx_classify.sv
module vpw_rx_classify
    import vpw_rx_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic level,
    output sym_e sym,
    output logic sym_bit,
    output logic sym_high,
    output logic sym_long
);
    localparam int unsigned CNT_W = $clog2(T_OVER + 1);
    localparam logic [CNT_W-1:0] C_MIN   = CNT_W'(T_MIN);
    localparam logic [CNT_W-1:0] C_SHORT = CNT_W'(T_SHORT_END);
    localparam logic [CNT_W-1:0] C_LONG  = CNT_W'(T_LONG_END);
    localparam logic [CNT_W-1:0] C_OVER  = CNT_W'(T_OVER);

    typedef struct packed {
        logic             lvl;
        logic [CNT_W-1:0] cnt;
        sym_e             sym;
        logic             bit_v;
        logic             high;
        logic             long_w;
    } cls_t;

    cls_t q, d;
    logic [CNT_W-1:0] cnt_inc;

    assign cnt_inc = q.cnt + 1'b1;

    always_comb begin
        d        = q;
        d.lvl    = level;
        d.sym    = SYM_NONE;
        d.bit_v  = 1'b0;
        d.high   = 1'b0;
        d.long_w = 1'b0;
        if (level != q.lvl) begin
            // a level just ended: sort it by its duration
            d.cnt  = '0;
            d.high = q.lvl;
            if (q.cnt < C_MIN) begin
                d.sym = SYM_BAD;
            end else if (q.cnt < C_SHORT) begin
                d.sym = SYM_BIT;
            end else if (q.cnt < C_LONG) begin
                d.sym    = SYM_BIT;
                d.long_w = 1'b1;
            end else if (q.cnt < C_OVER) begin
                // a low of this length was already reported on crossing
                d.sym = q.lvl ? SYM_SOF : SYM_NONE;
            end
            d.bit_v = d.long_w ^ ~q.lvl;
        end else if (tick && (q.cnt != C_OVER)) begin
            // a level still running: report thresholds as it crosses them
            d.cnt = cnt_inc;
            if (!q.lvl && (cnt_inc == C_LONG)) d.sym = SYM_EOD;
            if (cnt_inc == C_OVER)             d.sym = q.lvl ? SYM_BRK : SYM_EOF;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q     <= '0;
            q.sym <= SYM_NONE;
        end else begin
            q <= d;
        end
    end

    assign sym      = q.sym;
    assign sym_bit  = q.bit_v;
    assign sym_high = q.high;
    assign sym_long = q.long_w;
endmodule

// File: rtl/vpw_rx_frame.sv
module vpw_rx_frame
    import vpw_rx_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  sym_e       sym,
    input  logic       sym_bit,
    input  logic       sym_high,
    input  logic       sym_long,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_resp,
    output logic       ev_valid,
    output logic [2:0] ev_kind,
    output logic [2:0] ev_flags
);
    localparam int unsigned NB_W = $clog2(MAX_BYTES + 1);
    localparam logic [NB_W-1:0] NB_MAX = NB_W'(MAX_BYTES);

    typedef struct packed {
        fstate_e         st;
        logic [7:0]      sh;
        logic [2:0]      bits;
        logic [NB_W-1:0] nbytes;
        logic [7:0]      crc;
        logic            resp_crc;
        logic            err_frm;
        logic            err_len;
        logic            err_crc;
        logic            rx_v;
        logic [7:0]      rx_d;
        logic            rx_r;
        logic            ev_v;
        logic [2:0]      ev_k;
        logic [2:0]      ev_f;
    } frm_t;

    frm_t q, d;
    logic [7:0] sh_n;
    logic [7:0] crc_n;
    logic       last_bit;
    logic       crc_bad;

    assign sh_n     = {q.sh[6:0], sym_bit};
    assign crc_n    = crc_bit(q.crc, sym_bit);
    assign last_bit = (q.bits == 3'd7);
    assign crc_bad  = (q.crc != CRC_GOOD);

    always_comb begin
        d      = q;
        d.rx_v = 1'b0;
        d.ev_v = 1'b0;
        if (sym == SYM_BRK) begin
            d.ev_v = 1'b1;
            d.ev_k = EV_BRK;
            d.ev_f = 3'b000;
            d.st   = FS_IDLE;
        end else begin
            unique case (q.st)
                FS_IDLE: begin
                    if (sym == SYM_SOF) begin
                        d.ev_v     = 1'b1;
                        d.ev_k     = EV_SOF;
                        d.ev_f     = 3'b000;
                        d.st       = FS_DATA;
                        d.sh       = '0;
                        d.bits     = '0;
                        d.nbytes   = '0;
                        d.crc      = CRC_INIT;
                        d.resp_crc = 1'b0;
                        d.err_frm  = 1'b0;
                        d.err_len  = 1'b0;
                        d.err_crc  = 1'b0;
                    end
                end
                FS_DATA, FS_RESP: begin
                    unique case (sym)
                        SYM_NONE: ;
                        SYM_BIT: begin
                            d.sh   = sh_n;
                            d.crc  = crc_n;
                            d.bits = q.bits + 3'd1;
                            if (last_bit) begin
                                if (q.nbytes < NB_MAX) begin
                                    d.rx_v   = 1'b1;
                                    d.rx_d   = sh_n;
                                    d.rx_r   = (q.st == FS_RESP);
                                    d.nbytes = q.nbytes + 1'b1;
                                end else begin
                                    d.err_len = 1'b1;
                                end
                            end
                        end
                        SYM_EOD: begin
                            if (q.st == FS_DATA) begin
                                d.err_frm = q.err_frm | (q.bits != 3'd0) | (q.nbytes == '0);
                                d.err_crc = crc_bad;
                                d.ev_v    = 1'b1;
                                d.ev_k    = EV_EOD;
                                d.ev_f    = {d.err_frm, q.err_len, crc_bad};
                                d.st      = d.err_frm ? FS_TAIL : FS_GAP;
                            end else begin
                                d.err_frm = q.err_frm | (q.bits != 3'd0);
                                d.err_crc = q.err_crc | (q.resp_crc & crc_bad);
                                d.st      = FS_TAIL;
                            end
                        end
                        SYM_EOF: begin
                            d.ev_v = 1'b1;
                            d.ev_k = EV_EOF;
                            d.ev_f = {1'b1, q.err_len, q.err_crc};
                            d.st   = FS_IDLE;
                        end
                        default: begin
                            d.err_frm = 1'b1;
                            d.st      = FS_TAIL;
                        end
                    endcase
                end
                FS_GAP: begin
                    if (sym == SYM_BIT && sym_high) begin
                        d.ev_v     = 1'b1;
                        d.ev_k     = EV_NB;
                        d.ev_f     = {2'b00, sym_long};
                        d.resp_crc = sym_long;
                        d.crc      = CRC_INIT;
                        d.bits     = '0;
                        d.st       = FS_RESP;
                    end else if (sym == SYM_EOF) begin
                        d.ev_v = 1'b1;
                        d.ev_k = EV_EOF;
                        d.ev_f = {q.err_frm, q.err_len, q.err_crc};
                        d.st   = FS_IDLE;
                    end else if (sym != SYM_NONE) begin
                        d.err_frm = 1'b1;
                        d.st      = FS_TAIL;
                    end
                end
                FS_TAIL: begin
                    if (sym == SYM_EOF) begin
                        d.ev_v = 1'b1;
                        d.ev_k = EV_EOF;
                        d.ev_f = {q.err_frm, q.err_len, q.err_crc};
                        d.st   = FS_IDLE;
                    end else if (sym != SYM_NONE) begin
                        d.err_frm = 1'b1;
                    end
                end
                default: d.st = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q    <= '0;
            q.st <= FS_IDLE;
        end else begin
            q <= d;
        end
    end

    assign rx_valid = q.rx_v;
    assign rx_data  = q.rx_d;
    assign rx_resp  = q.rx_r;
    assign ev_valid = q.ev_v;
    assign ev_kind  = q.ev_k;
    assign ev_flags = q.ev_f;
endmodule

// File: rtl/vpw_frame_rx.sv
module vpw_frame_rx
    import vpw_rx_pkg::*;
#(
    parameter int unsigned CLKS_PER_US = 16,
    parameter int unsigned FILT_CLKS   = 4,
    parameter int unsigned MAX_BYTES   = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fast_mode,
    input  logic       bus_in,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_resp,
    output logic       ev_valid,
    output logic [2:0] ev_kind,
    output logic [2:0] ev_flags
);
    logic tick;
    logic level;
    sym_e sym;
    logic sym_bit;
    logic sym_high;
    logic sym_long;

    vpw_rx_tick #(.CLKS_PER_US(CLKS_PER_US)) tick_i (
        .clk(clk), .rst(rst), .fast_mode(fast_mode), .tick(tick)
    );

    vpw_rx_filter #(.FILT_CLKS(FILT_CLKS)) filt_i (
        .clk(clk), .rst(rst), .bus_raw(bus_in), .level(level)
    );

    vpw_rx_classify cls_i (
        .clk(clk), .rst(rst), .tick(tick), .level(level),
        .sym(sym), .sym_bit(sym_bit), .sym_high(sym_high), .sym_long(sym_long)
    );

    vpw_rx_frame #(.MAX_BYTES(MAX_BYTES)) frm_i (
        .clk(clk), .rst(rst),
        .sym(sym), .sym_bit(sym_bit), .sym_high(sym_high), .sym_long(sym_long),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_resp(rx_resp),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_flags(ev_flags)
    );
endmodule

// File: rtl/vpw_frame_rx_chk.sv
module vpw_frame_rx_chk
    import vpw_rx_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 12
) (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic       rx_resp,
    input logic       ev_valid,
    input logic [2:0] ev_kind
);
    localparam int unsigned CW = $clog2(MAX_BYTES + 2);
    localparam logic [CW-1:0] CAP = CW'(MAX_BYTES);

    logic [CW-1:0] seen_q;
    logic          brk_q;
    logic          nb_q;
    logic          open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
            brk_q  <= 1'b0;
            nb_q   <= 1'b0;
            open_q <= 1'b0;
        end else if (ev_valid && ev_kind == EV_SOF) begin
            seen_q <= '0;
            brk_q  <= 1'b0;
            nb_q   <= 1'b0;
            open_q <= 1'b1;
        end else begin
            if (rx_valid && seen_q <= CAP) seen_q <= seen_q + 1'b1;
            if (ev_valid && ev_kind == EV_BRK) begin
                brk_q  <= 1'b1;
                open_q <= 1'b0;
            end
            if (ev_valid && ev_kind == EV_NB)  nb_q   <= 1'b1;
            if (ev_valid && ev_kind == EV_EOF) open_q <= 1'b0;
        end
    end

    a_r11_one_report: assert property (@(posedge clk) disable iff (rst)
        !(rx_valid && ev_valid));

    a_r7_byte_cap: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (seen_q < CAP));

    a_r8_silent_after_break: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> !brk_q);

    a_r5_resp_after_nb: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_resp) |-> nb_q);

    a_r6_eof_in_frame: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && ev_kind == EV_EOF) |-> open_q);

    a_r2_bytes_in_frame: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> open_q);
endmodule

bind vpw_frame_rx vpw_frame_rx_chk #(.MAX_BYTES(MAX_BYTES)) chk_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_resp(rx_resp),
    .ev_valid(ev_valid), .ev_kind(ev_kind)
);

// File: tb/vpw_frame_rx_tb_top.sv
module vpw_frame_rx_tb_top;
    localparam int unsigned CPU = 4;
    localparam logic [2:0] K_SOF = 3'd0, K_EOD = 3'd1, K_NB = 3'd2, K_EOF = 3'd3, K_BRK = 3'd4;

    typedef logic [7:0] bq_t[$];

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fast_mode = 1'b0;
    logic bus_in = 1'b0;
    logic       rx_valid, rx_resp, ev_valid;
    logic [7:0] rx_data;
    logic [2:0] ev_kind, ev_flags;

    int n_chk = 0;
    int n_err = 0;
    int both_cnt = 0;
    int cpt = CPU;

    logic [8:0] exp_b[$], got_b[$];
    logic [5:0] exp_e[$], got_e[$];

    always #5 clk = ~clk;

    vpw_frame_rx #(.CLKS_PER_US(CPU), .FILT_CLKS(3), .MAX_BYTES(12)) dut_i (
        .clk(clk), .rst(rst), .fast_mode(fast_mode), .bus_in(bus_in),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_resp(rx_resp),
        .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_flags(ev_flags)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) got_b.push_back({rx_resp, rx_data});
            if (ev_valid) got_e.push_back({ev_kind, ev_flags});
            if (rx_valid && ev_valid) both_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic compare(input string tag);
        check(got_b.size() == exp_b.size(), {tag, " byte count"}, got_b.size(), exp_b.size());
        for (int i = 0; i < exp_b.size() && i < got_b.size(); i++)
            check(got_b[i] == exp_b[i], {tag, " byte"}, got_b[i], exp_b[i]);
        check(got_e.size() == exp_e.size(), {tag, " event count"}, got_e.size(), exp_e.size());
        for (int i = 0; i < exp_e.size() && i < got_e.size(); i++)
            check(got_e[i] == exp_e[i], {tag, " event"}, got_e[i], exp_e[i]);
        exp_b.delete(); got_b.delete(); exp_e.delete(); got_e.delete();
    endtask

    task automatic hold(input logic lv, input int ticks);
        bus_in = lv;
        repeat (ticks * cpt) @(negedge clk);
    endtask

    // 1 = low short / high long, 0 = low long / high short
    task automatic send_bytes(input bq_t m);
        logic lv;
        lv = 1'b0;
        foreach (m[i]) begin
            for (int k = 7; k >= 0; k--) begin
                logic lng;
                lng = lv ? m[i][k] : ~m[i][k];
                hold(lv, lng ? 128 : 64);
                lv = ~lv;
            end
        end
    endtask

    function automatic logic [7:0] fcs(input bq_t m);
        logic [7:0] r;
        r = 8'hFF;
        foreach (m[i]) begin
            for (int k = 7; k >= 0; k--) begin
                logic fb;
                fb = r[7] ^ m[i][k];
                r = {r[6:0], 1'b0};
                if (fb) r = r ^ 8'h1D;
            end
        end
        return ~r;
    endfunction

    function automatic bq_t mk_msg(input int n, input bit bad);
        bq_t m;
        logic [7:0] c;
        for (int i = 0; i < n; i++) m.push_back(8'($urandom));
        c = fcs(m);
        if (bad) c = c ^ 8'h01;
        m.push_back(c);
        return m;
    endfunction

    task automatic send_frame(input bq_t dat, input int nb_mode, input bq_t rsp,
                              input bit dbad, input bit rbad, input bit sof_glitch,
                              input string tag);
        int total;
        total = 0;
        exp_e.push_back({K_SOF, 3'b000});
        foreach (dat[i]) begin
            if (total < 12) exp_b.push_back({1'b0, dat[i]});
            total++;
        end
        exp_e.push_back({K_EOD, 1'b0, dat.size() > 12, dbad});
        if (nb_mode != 0) begin
            exp_e.push_back({K_NB, 2'b00, nb_mode == 2});
            foreach (rsp[i]) begin
                if (total < 12) exp_b.push_back({1'b1, rsp[i]});
                total++;
            end
        end
        exp_e.push_back({K_EOF, 1'b0, total > 12, dbad | ((nb_mode == 2) & rbad)});
        if (sof_glitch) begin
            hold(1'b1, 100);
            bus_in = 1'b0;
            repeat (2) @(negedge clk);
            hold(1'b1, 100);
        end else begin
            hold(1'b1, 200);
        end
        send_bytes(dat);
        if (nb_mode != 0) begin
            hold(1'b0, 200);
            hold(1'b1, nb_mode == 2 ? 128 : 64);
            send_bytes(rsp);
        end
        hold(1'b0, 300);
        compare(tag);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not end, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        bq_t d, r, none;
        void'($urandom(32'h5EED));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12: quiet outputs after reset
        check(!rx_valid && !ev_valid, "R12 reset outputs", {rx_valid, ev_valid}, 0);

        // R1: a two-clock pulse on the idle bus is ignored; idle low raises nothing
        hold(1'b0, 300);
        bus_in = 1'b1;
        repeat (2) @(negedge clk);
        hold(1'b0, 300);
        compare("R1 idle glitch");

        // normal speed
        d = mk_msg(2, 1'b0);
        send_frame(d, 0, none, 1'b0, 1'b0, 1'b0, "R2 R3 R4 R6 plain frame");
        d = mk_msg(2, 1'b1);
        send_frame(d, 0, none, 1'b1, 1'b0, 1'b0, "R4 R6 bad check byte");
        d = mk_msg(2, 1'b0);
        r = mk_msg(1, 1'b0);
        send_frame(d, 2, r, 1'b0, 1'b0, 1'b0, "R5 long NB response");

        // four-times speed
        fast_mode = 1'b1;
        cpt = CPU / 4;
        hold(1'b0, 300);
        for (int f = 0; f < 6; f++) begin
            int nbm;
            bit db, rb;
            db  = ($urandom_range(0, 3) == 0);
            rb  = ($urandom_range(0, 2) == 0);
            nbm = $urandom_range(0, 2);
            d = mk_msg($urandom_range(1, 4), db);
            r = mk_msg($urandom_range(1, 2), rb);
            send_frame(d, nbm, r, db, rb, 1'b0, "R10 R3 R5 random frame");
        end

        // R7: thirteen bytes, last one dropped
        d = mk_msg(12, 1'b0);
        send_frame(d, 0, none, 1'b0, 1'b0, 1'b0, "R7 over-length frame");
        d = mk_msg(8, 1'b0);
        r = mk_msg(4, 1'b0);
        send_frame(d, 1, r, 1'b0, 1'b0, 1'b0, "R7 R5 length across response");

        // R8: break aborts, bits after it deliver nothing
        exp_e.push_back({K_SOF, 3'b000});
        exp_b.push_back({1'b0, 8'hA5});
        exp_e.push_back({K_BRK, 3'b000});
        hold(1'b1, 200);
        d = {8'hA5};
        send_bytes(d);
        hold(1'b0, 64);
        hold(1'b1, 300);
        hold(1'b0, 300);
        for (int k = 0; k < 8; k++) hold(k[0] ? 1'b0 : 1'b1, 64);
        hold(1'b0, 300);
        compare("R8 break");

        // R9: too-short pulse stops delivery, EOF carries framing flag
        exp_e.push_back({K_SOF, 3'b000});
        exp_b.push_back({1'b0, 8'h3C});
        exp_e.push_back({K_EOF, 3'b100});
        hold(1'b1, 200);
        d = {8'h3C};
        send_bytes(d);
        hold(1'b0, 20);
        for (int k = 0; k < 7; k++) hold(k[0] ? 1'b0 : 1'b1, 64);
        hold(1'b0, 300);
        compare("R9 short pulse");

        // R1: glitch inside the start symbol leaves the frame intact
        d = mk_msg(1, 1'b0);
        send_frame(d, 0, none, 1'b0, 1'b0, 1'b1, "R1 glitch in start");

        check(both_cnt == 0, "R11 single report", both_cnt, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end
endmodule